// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control sequencer of a successive-approximation ADC. Software reaches it through a small word-addressed register bus. Writing the channel-control word picks one of 31 input channels and an interrupt enable, and starts a conversion. The sequencer paces the conversion with a divided ADC clock. It first waits a fixed settling period. It then runs one or more sampling passes. Each pass lasts a base time plus a selectable long-sample extension. When the last pass ends, it latches the averaged result, sets a completion flag and can raise an interrupt.

The analog converter core sits outside the block. The block presents the selected channel on `conv_chan`. It pulses `samp_take` in the cycle it reads `samp_data`, which is at the end of every pass. This port has no back-pressure: the core must hold a valid sample on `samp_data` whenever `samp_take` can fire. Conversion can be one-shot or continuous. The channel code 0x1F stops the sequencer. A channel write during a running conversion aborts that conversion and starts a new one.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, the channel word reads 0x1F with the interrupt enable clear. The flag, the result, the configuration, the general control word and `irq` are all zero.
- R2: A write to offset 0x00 with a channel field (bits 4:0) other than 0x1F starts a conversion. The completion flag rises exactly 6 + N*(25 + L) ADC clock ticks after that write. N is the averaging count and L is the long-sample extension.
- R3: L is set by the configuration word at offset 0x14. When bit 4 is clear, field bits 9:8 equal to 0..3 give L = 3, 5, 7, 9. When bit 4 is set, the same field values give L = 13, 17, 21, 25.
- R4: Configuration bits 1:0 choose the tick source: 0 = bus clock, 1 = bus clock / 2, 2 = `alt_tick`, 3 = `async_tick`. Bits 6:5 divide that source by 1, 2, 4 or 8. The divider restarts with each conversion.
- R5: Setting general-control bit 5 (offset 0x18) turns averaging on, with N = 4, 8, 16 or 32 chosen by configuration bits 15:14. Otherwise N = 1. `samp_data` is read at the end of each pass, and the result is floor(sum / N).
- R6: The status word at 0x08 holds the flag in bit 0, and the result word at 0x0C holds the result in bits 11:0. Reading 0x0C clears the flag. `irq` is high exactly when the flag and channel-word bit 7 are both set.
- R7: While general-control bit 6 is set, each completion restarts a conversion on the same channel. After the bit is cleared, the conversion in progress finishes and no further conversion starts.
- R8: Writing channel code 0x1F stops any conversion, so no completion follows.
- R9: A channel write during a conversion aborts it. The new conversion is timed from that write.
- R10: If configuration bit 16 is set, a completion overwrites an unread result. If it is clear, a result that completes while the flag is still set is discarded.
- R11: An access at a non-word-aligned address or above 0x30 reads zero and changes nothing.
- R12: `conv_chan` shows the channel field of the channel word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_rd` is high |
| alt_tick | input | 1 | Alternate clock enable strobe |
| async_tick | input | 1 | Asynchronous-source clock enable strobe (already synchronised) |
| samp_data | input | 12 | Sample from the converter core |
| samp_take | output | 1 | Sample is read this cycle |
| conv_chan | output | 5 | Selected input channel |
| irq | output | 1 | Completion interrupt |

## Verification
Assertions in the RTL check several rules on every cycle. A start always loads the settling count. A stop always returns the engine to idle. One-shot and continuous completions lead to idle or to a restart, as selected. A result is latched or held according to the overwrite bit and the flag. A result read clears the flag. The divided tick never fires twice in a row at ratios above one. Only the bench scenarios can show the end-to-end values: exact completion latencies for each extension, divider and source; averaged results over ramped samples; abort and stop behaviour; and the fact that bad addresses leave the state untouched.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_PASS} seq_state_t;

  localparam int unsigned CHAN_W = 5;
  localparam logic [CHAN_W-1:0] CHAN_STOP = '1;

  localparam logic [7:0] OFS_CHAN = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_RES  = 8'h0C;
  localparam logic [7:0] OFS_CFG  = 8'h14;
  localparam logic [7:0] OFS_GCTL = 8'h18;
  localparam logic [7:0] OFS_LAST = 8'h30;

  localparam logic [31:0] CFG_KEEP  = 32'h0001_C373;
  localparam logic [31:0] GCTL_KEEP = 32'h0000_0060;

  localparam int unsigned IE_BIT     = 7;
  localparam int unsigned LONG_BIT   = 4;
  localparam int unsigned OVW_BIT    = 16;
  localparam int unsigned AVGEN_BIT  = 5;
  localparam int unsigned CONT_BIT   = 6;
endpackage

// File: rtl/adcseq_tick.sv
module adcseq_tick #(
  parameter int unsigned DIVSEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic [1:0]          src_sel,
  input  logic [DIVSEL_W-1:0] div_sel,
  input  logic                alt_tick,
  input  logic                async_tick,
  output logic                tick
);
  localparam int unsigned CNT_W = (1 << DIVSEL_W) - 1;

  logic             half_q;
  logic             src_tick;
  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] ratio_m1;

  always_comb begin
    unique case (src_sel)
      2'd0:    src_tick = 1'b1;
      2'd1:    src_tick = half_q;
      2'd2:    src_tick = alt_tick;
      default: src_tick = async_tick;
    endcase
  end

  assign ratio_m1 = CNT_W'((CNT_W+1)'(1) << div_sel) - CNT_W'(1);
  assign tick     = src_tick && (div_cnt == ratio_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      div_cnt <= '0;
    end else if (clear) begin
      half_q  <= 1'b0;
      div_cnt <= '0;
    end else begin
      half_q <= ~half_q;
      if (src_tick) div_cnt <= tick ? '0 : div_cnt + CNT_W'(1);
    end
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div_sel != '0) |=> !tick || (div_sel == '0));
endmodule

// File: rtl/adcseq_engine.sv
module adcseq_engine
  import adcseq_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 12,
  parameter int unsigned STARTUP_CYC = 6,
  parameter int unsigned LEN_W       = 6,
  parameter int unsigned MAX_LOG     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          stop,
  input  logic                          cont,
  input  logic                          tick,
  input  logic [LEN_W-1:0]              pass_len,
  input  logic [$clog2(MAX_LOG+1)-1:0]  pass_log2,
  input  logic [SAMPLE_W-1:0]           samp_data,
  output logic                          samp_take,
  output logic                          fin,
  output logic                          div_clear,
  output logic [SAMPLE_W-1:0]           avg_val
);
  localparam int unsigned ACC_W  = SAMPLE_W + MAX_LOG;
  localparam int unsigned PCNT_W = MAX_LOG + 1;
  localparam logic [LEN_W-1:0] SETTLE_M1 = LEN_W'(STARTUP_CYC - 1);

  seq_state_t        state;
  logic [LEN_W-1:0]  cnt;
  logic [PCNT_W-1:0] pass_cnt;
  logic [PCNT_W-1:0] passes_m1;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  acc_next;
  logic              last_pass;

  assign passes_m1 = (PCNT_W'(1) << pass_log2) - PCNT_W'(1);
  assign last_pass = (pass_cnt == passes_m1);
  assign acc_next  = acc + ACC_W'(samp_data);
  assign avg_val   = SAMPLE_W'(acc_next >> pass_log2);
  assign samp_take = tick && (state == ST_PASS) && (cnt == '0) && !start && !stop;
  assign fin       = samp_take && last_pass;
  assign div_clear = start || (fin && cont);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pass_cnt <= '0;
      acc      <= '0;
    end else if (stop) begin
      state <= ST_IDLE;
    end else if (start) begin
      state    <= ST_SETTLE;
      cnt      <= SETTLE_M1;
      pass_cnt <= '0;
      acc      <= '0;
    end else if (tick) begin
      unique case (state)
        ST_SETTLE: begin
          if (cnt == '0) begin
            state <= ST_PASS;
            cnt   <= pass_len - LEN_W'(1);
          end else begin
            cnt <= cnt - LEN_W'(1);
          end
        end
        ST_PASS: begin
          if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
          end else if (last_pass) begin
            acc      <= '0;
            pass_cnt <= '0;
            if (cont) begin
              state <= ST_SETTLE;
              cnt   <= SETTLE_M1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            pass_cnt <= pass_cnt + PCNT_W'(1);
            acc      <= acc_next;
            cnt      <= pass_len - LEN_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  start_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !stop |=> (state == ST_SETTLE) && (cnt == SETTLE_M1));
  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> state == ST_IDLE);
  // R7
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !cont |=> state == ST_IDLE);
  // R7
  cont_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin && cont |=> state == ST_SETTLE);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adcseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SAMPLE_W    = 12,
  parameter int unsigned STARTUP_CYC = 6,
  parameter int unsigned BASE_CYC    = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                alt_tick,
  input  logic                async_tick,
  input  logic [SAMPLE_W-1:0] samp_data,
  output logic                samp_take,
  output logic [CHAN_W-1:0]   conv_chan,
  output logic                irq
);
  localparam int unsigned LEN_W   = 6;
  localparam int unsigned MAX_LOG = 5;
  localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1);

  logic [CHAN_W-1:0]   chan_q;
  logic                ie_q;
  logic [DATA_W-1:0]   cfg_q;
  logic [DATA_W-1:0]   gctl_q;
  logic                flag_q;
  logic [SAMPLE_W-1:0] result_q;

  logic addr_ok, chan_wr, res_rd, start, stop;
  logic tick, fin, div_clear;
  logic [SAMPLE_W-1:0] avg_val;
  logic [LEN_W-1:0]    lst_len, pass_len;
  logic [LOG_W-1:0]    pass_log2;

  assign addr_ok = (bus_addr[1:0] == 2'b00) && (bus_addr <= ADDR_W'(OFS_LAST));
  assign chan_wr = bus_wr && addr_ok && (bus_addr == ADDR_W'(OFS_CHAN));
  assign res_rd  = bus_rd && addr_ok && (bus_addr == ADDR_W'(OFS_RES));
  assign start   = chan_wr && (bus_wdata[CHAN_W-1:0] != CHAN_STOP);
  assign stop    = chan_wr && (bus_wdata[CHAN_W-1:0] == CHAN_STOP);

  assign lst_len   = cfg_q[LONG_BIT] ? LEN_W'(6'd13 + {2'b00, cfg_q[9:8], 2'b00})
                                     : LEN_W'(6'd3 + {3'b000, cfg_q[9:8], 1'b0});
  assign pass_len  = LEN_W'(BASE_CYC) + lst_len;
  assign pass_log2 = gctl_q[AVGEN_BIT] ? LOG_W'(3'd2 + {1'b0, cfg_q[15:14]}) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= CHAN_STOP;
      ie_q   <= 1'b0;
      cfg_q  <= '0;
      gctl_q <= '0;
    end else if (bus_wr && addr_ok) begin
      if (bus_addr == ADDR_W'(OFS_CHAN)) begin
        chan_q <= bus_wdata[CHAN_W-1:0];
        ie_q   <= bus_wdata[IE_BIT];
      end
      if (bus_addr == ADDR_W'(OFS_CFG))  cfg_q  <= bus_wdata & CFG_KEEP;
      if (bus_addr == ADDR_W'(OFS_GCTL)) gctl_q <= bus_wdata & GCTL_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      result_q <= '0;
    end else if (fin) begin
      flag_q <= 1'b1;
      if (!flag_q || cfg_q[OVW_BIT]) result_q <= avg_val;
    end else if (res_rd) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && addr_ok) begin
      unique case (bus_addr)
        ADDR_W'(OFS_CHAN): bus_rdata = DATA_W'({ie_q, 2'b00, chan_q});
        ADDR_W'(OFS_STAT): bus_rdata = DATA_W'(flag_q);
        ADDR_W'(OFS_RES):  bus_rdata = DATA_W'(result_q);
        ADDR_W'(OFS_CFG):  bus_rdata = cfg_q;
        ADDR_W'(OFS_GCTL): bus_rdata = gctl_q;
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign conv_chan = chan_q;
  assign irq       = flag_q && ie_q;

  adcseq_tick #(.DIVSEL_W(2)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear(div_clear),
    .src_sel(cfg_q[1:0]), .div_sel(cfg_q[6:5]),
    .alt_tick(alt_tick), .async_tick(async_tick), .tick(tick)
  );

  adcseq_engine #(
    .SAMPLE_W(SAMPLE_W), .STARTUP_CYC(STARTUP_CYC), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cont(gctl_q[CONT_BIT]),
    .tick(tick), .pass_len(pass_len), .pass_log2(pass_log2), .samp_data(samp_data),
    .samp_take(samp_take), .fin(fin), .div_clear(div_clear), .avg_val(avg_val)
  );

  // R5
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin && (!flag_q || cfg_q[OVW_BIT]) |=> result_q == $past(avg_val));
  // R10
  ovw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin && flag_q && !cfg_q[OVW_BIT] |=> $stable(result_q) && flag_q);
  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd && !fin |=> !flag_q);
endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alt_tick = 1'b0, async_tick = 1'b0;
  logic [11:0] samp_data;
  logic        samp_take;
  logic [4:0]  conv_chan;
  logic        irq;

  logic        use_ramp = 1'b0, ramp_clr = 1'b0;
  logic [11:0] fixed_val = '0;
  int          ramp_idx = 0;
  int          cyc = 0, t_wr = 0, t_start = 0;
  int          n_checks = 0, n_fails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    if (ramp_clr) ramp_idx <= 0;
    else if (samp_take) ramp_idx <= ramp_idx + 1;
  end
  assign samp_data = use_ramp ? 12'(100 + 3 * ramp_idx) : fixed_val;

  adc_conv_seq u_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_tick(alt_tick),
    .async_tick(async_tick), .samp_data(samp_data), .samp_take(samp_take),
    .conv_chan(conv_chan), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    t_wr = cyc; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output int v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic start_conv(input logic [31:0] d);
    bus_write(8'h00, d);
    t_start = t_wr;
  endtask

  task automatic wait_irq(input int limit, output int k);
    while (!irq && (cyc - t_start) < limit) @(negedge clk);
    k = irq ? (cyc - t_start) : -1;
  endtask

  task automatic t_reset;
    int v;
    check("R1 irq", int'(irq), 0);
    bus_read(8'h00, v); check("R1 channel word", v, 32'h1F);
    bus_read(8'h08, v); check("R1 status", v, 0);
    bus_read(8'h0C, v); check("R1 result", v, 0);
    bus_read(8'h14, v); check("R1 config", v, 0);
    bus_read(8'h18, v); check("R1 gctl", v, 0);
  endtask

  task automatic t_basic;
    int k, v;
    fixed_val = 12'hABC;
    start_conv(32'h85);
    check("R12 conv_chan", int'(conv_chan), 5);
    wait_irq(500, k); check("R2 latency 6+1*(25+3)", k, 34);
    bus_read(8'h08, v); check("R6 flag set", v, 1);
    bus_read(8'h0C, v); check("R6 result", v, 12'hABC);
    bus_read(8'h08, v); check("R6 flag cleared by read", v, 0);
    check("R6 irq low", int'(irq), 0);
  endtask

  task automatic timed(input string req, input logic [31:0] cfg, input int exp);
    int k, v;
    bus_write(8'h14, cfg);
    start_conv(32'h81);
    wait_irq(2000, k); check(req, k, exp);
    bus_read(8'h0C, v);
  endtask

  task automatic t_lst;
    timed("R3 long field2 L=21", 32'h210, 52);
    timed("R3 short field3 L=9", 32'h300, 40);
  endtask

  task automatic t_div;
    timed("R4 bus div4", 32'h40, 136);
    timed("R4 bus/2 div8", 32'h61, 544);
  endtask

  task automatic t_ext_src;
    int k, v;
    bus_write(8'h14, 32'h2);
    alt_tick = 1'b0;
    start_conv(32'h81);
    repeat (60) @(negedge clk);
    check("R4 alt source idle holds", int'(irq), 0);
    alt_tick = 1'b1;
    start_conv(32'h81);
    wait_irq(500, k); check("R4 alt source", k, 34);
    bus_read(8'h0C, v);
    alt_tick = 1'b0; async_tick = 1'b1;
    timed("R4 async source", 32'h3, 34);
    async_tick = 1'b0;
    bus_write(8'h14, 32'h0);
  endtask

  task automatic avg_run(input string req, input logic [31:0] cfg, input int exp_t, input int exp_v);
    int k, v;
    bus_write(8'h14, cfg);
    @(negedge clk); ramp_clr = 1'b1; @(negedge clk); ramp_clr = 1'b0;
    start_conv(32'h81);
    wait_irq(2000, k); check({req, " latency"}, k, exp_t);
    bus_read(8'h0C, v); check({req, " average"}, v, exp_v);
  endtask

  task automatic t_avg;
    use_ramp = 1'b1;
    bus_write(8'h18, 32'h20);
    avg_run("R5 N=4", 32'h0, 118, 104);
    avg_run("R5 N=32", 32'hC000, 902, 146);
    bus_write(8'h18, 32'h0);
    bus_write(8'h14, 32'h0);
    use_ramp = 1'b0;
  endtask

  task automatic t_cont;
    int k, v;
    bus_write(8'h18, 32'h40);
    fixed_val = 12'h0AA;
    start_conv(32'h81);
    wait_irq(500, k); check("R7 first", k, 34);
    bus_read(8'h0C, v); check("R7 first value", v, 12'h0AA);
    fixed_val = 12'h0BB;
    wait_irq(500, k); check("R7 restart", k, 68);
    bus_read(8'h0C, v); check("R7 second value", v, 12'h0BB);
    bus_write(8'h18, 32'h0);
    wait_irq(500, k); check("R7 last in flight", k, 102);
    bus_read(8'h0C, v);
    repeat (60) @(negedge clk);
    check("R7 no restart after clear", int'(irq), 0);
  endtask

  task automatic t_stop;
    int v;
    start_conv(32'h81);
    repeat (10) @(negedge clk);
    bus_write(8'h00, 32'h1F);
    repeat (60) @(negedge clk);
    bus_read(8'h08, v); check("R8 no completion after stop", v, 0);
    check("R12 conv_chan stop", int'(conv_chan), 5'h1F);
  endtask

  task automatic t_abort;
    int k, v;
    fixed_val = 12'h123;
    start_conv(32'h83);
    repeat (10) @(negedge clk);
    start_conv(32'h87);
    check("R12 conv_chan new", int'(conv_chan), 7);
    wait_irq(500, k); check("R9 timed from rewrite", k, 34);
    bus_read(8'h0C, v); check("R9 result", v, 12'h123);
  endtask

  task automatic t_ovw;
    int k, v;
    fixed_val = 12'h111;
    start_conv(32'h81);
    wait_irq(500, k);
    fixed_val = 12'h222;
    start_conv(32'h81);
    repeat (40) @(negedge clk);
    bus_read(8'h0C, v); check("R10 unread kept", v, 12'h111);
    bus_write(8'h14, 32'h10000);
    fixed_val = 12'h333;
    start_conv(32'h81);
    wait_irq(500, k);
    fixed_val = 12'h444;
    start_conv(32'h81);
    repeat (40) @(negedge clk);
    bus_read(8'h0C, v); check("R10 overwritten", v, 12'h444);
    bus_write(8'h14, 32'h0);
  endtask

  task automatic t_badaddr;
    int v;
    bus_write(8'h01, 32'h85);
    bus_write(8'h40, 32'h85);
    bus_write(8'h15, 32'h40);
    repeat (60) @(negedge clk);
    check("R11 no start", int'(irq), 0);
    bus_read(8'h00, v); check("R11 channel word kept", v, 32'h81);
    bus_read(8'h14, v); check("R11 config kept", v, 0);
    bus_read(8'h40, v); check("R11 out of range reads 0", v, 0);
    bus_read(8'h01, v); check("R11 unaligned reads 0", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_lst();
    t_div();
    t_ext_src();
    t_avg();
    t_cont();
    t_stop();
    t_abort();
    t_ovw();
    t_badaddr();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule